// File: doc/BRIEF.md
# User-Level Status and Counter Register Unit

This block is the register unit that a small 32-bit processor core reaches through its register-access instructions. It keeps two floating-point control fields: a five-bit set of sticky exception flags and a three-bit dynamic rounding mode. A third address exposes both fields together as one combined status word. The block also runs three 64-bit counters: clock cycles, external time ticks and retired instructions. Software reads these counters as 32-bit low and high halves.

Each access carries a 12-bit address, a 2-bit operation, 32-bit operand data and a valid strobe. The unit returns the addressed value combinationally from its current state, together with a flag that marks the access as illegal. It computes a read-modify-write result and stores it at the next clock edge.

Every floating-point operation can report exception bits, and the unit ORs them into the stored flags. A counter address refuses any access that would modify it. The same happens for any address outside the map.

Top module: `csr_unit`

## Requirements
- R1: Address 0x001 reads the five accrued exception flags in bits [4:0], with bits [31:5] reading zero. Write, set and clear operations act on bits [4:0] only.
- R2: Address 0x002 reads the rounding mode in bits [2:0], with bits [31:3] reading zero. Write, set and clear operations act on bits [2:0] only.
- R3: Address 0x003 reads {24'b0, rounding mode, flags}, with the mode in bits [7:5] and the flags in bits [4:0]. Modifying this address updates both fields, and bits [31:8] ignore writes.
- R4: When fpu_flag_valid is high at a clock edge, fpu_flags is ORed into the stored flags. Those bits stay set until software clears or overwrites them.
- R5: When a software modification of the flags and a hardware flag report fall in the same cycle, the stored result is the software value ORed with the reported flags.
- R6: Addresses 0xC00, 0xC01 and 0xC02 return the low 32 bits of the cycle, time and retired-instruction counters, in that order.
- R7: Addresses 0xC80, 0xC81 and 0xC82 return the high 32 bits of the same three counters, in the same order.
- R8: All counters are zero after reset. The cycle counter adds one on every clock, the time counter adds one on each time_tick, and the retired-instruction counter adds one on each retire_pulse.
- R9: A write to any counter address raises csr_illegal and changes no state. So does a set or clear with a nonzero operand.
- R10: An access to any address outside the mapped set raises csr_illegal and changes no state.
- R11: A set or clear whose operand is zero counts as a pure read. It is legal on counter addresses and leaves the register unchanged.
- R12: The operation encoding is 0 = read, 1 = write, 2 = set bits, 3 = clear bits. csr_rdata follows csr_addr combinationally, a modification takes effect at the next rising edge, and csr_illegal is low whenever csr_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_valid | input | 1 | Access strobe |
| csr_addr | input | 12 | Register address |
| csr_op | input | 2 | Operation: read, write, set, clear |
| csr_wdata | input | 32 | Operand for write, set or clear |
| csr_rdata | output | 32 | Current value of the addressed register |
| csr_illegal | output | 1 | Access refused |
| retire_pulse | input | 1 | One instruction retired this cycle |
| time_tick | input | 1 | Real-time tick |
| fpu_flag_valid | input | 1 | fpu_flags carries a report this cycle |
| fpu_flags | input | 5 | Exception bits from one floating-point operation |

## Verification
The assertions assume that reset is held for at least one edge before any access, and that all inputs are known at every sampled edge. They also assume that a fresh flag report may arrive in any cycle, including one that carries a software modification. The stimulus drives every input on the falling edge, keeps fpu_flag_valid low except in the directed sticky-flag and collision tests, and starts accesses only after the opening reset.

// File: rtl/csr_pkg.sv
package csr_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_FLAGS,
    SEL_RMODE,
    SEL_FSTAT,
    SEL_CNT_LO,
    SEL_CNT_HI
  } csr_sel_e;

  localparam logic [11:0] ADR_FLAGS = 12'h001;
  localparam logic [11:0] ADR_RMODE = 12'h002;
  localparam logic [11:0] ADR_FSTAT = 12'h003;
  localparam logic [3:0]  CNT_PAGE  = 4'hC;

  localparam int NUM_CNT = 3;

endpackage

// File: rtl/csr_decode.sv
module csr_decode
  import csr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter bit HAS_HI = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  output csr_sel_e          sel,
  output logic [1:0]        cnt_idx,
  output logic              read_only
);

  always_comb begin
    sel       = SEL_NONE;
    cnt_idx   = addr[1:0];
    read_only = 1'b0;
    if (addr == ADR_FLAGS) begin
      sel = SEL_FLAGS;
    end else if (addr == ADR_RMODE) begin
      sel = SEL_RMODE;
    end else if (addr == ADR_FSTAT) begin
      sel = SEL_FSTAT;
    end else if (addr[11:8] == CNT_PAGE && addr[6:2] == 5'd0 &&
                 addr[1:0] != 2'b11) begin
      if (!addr[7]) begin
        sel       = SEL_CNT_LO;
        read_only = 1'b1;
      end else if (HAS_HI) begin
        sel       = SEL_CNT_HI;
        read_only = 1'b1;
      end
    end
  end

endmodule

// File: rtl/csr_counter.sv
module csr_counter #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [WIDTH-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (inc) count <= count + 1'b1;
  end

endmodule

// File: rtl/csr_fp_state.sv
module csr_fp_state #(
  parameter int FLAG_W = 5,
  parameter int RM_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_flags_we,
  input  logic [FLAG_W-1:0] sw_flags,
  input  logic              sw_rm_we,
  input  logic [RM_W-1:0]   sw_rm,
  input  logic              hw_valid,
  input  logic [FLAG_W-1:0] hw_flags,
  output logic [FLAG_W-1:0] flags,
  output logic [RM_W-1:0]   rmode
);

  logic [FLAG_W-1:0] base_flags;
  logic [FLAG_W-1:0] hw_or;

  always_comb begin
    base_flags = sw_flags_we ? sw_flags : flags;
    hw_or      = hw_valid ? hw_flags : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      rmode <= '0;
    end else begin
      flags <= base_flags | hw_or;
      if (sw_rm_we) rmode <= sw_rm;
    end
  end

endmodule

// File: rtl/csr_unit.sv
module csr_unit
  import csr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 64,
  parameter int FLAG_W = 5,
  parameter int RM_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_valid,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [1:0]        csr_op,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  output logic              csr_illegal,
  input  logic              retire_pulse,
  input  logic              time_tick,
  input  logic              fpu_flag_valid,
  input  logic [FLAG_W-1:0] fpu_flags
);

  localparam bit HAS_HI = (CNT_W > DATA_W);
  localparam int STAT_W = FLAG_W + RM_W;

  csr_sel_e          sel;
  logic [1:0]        cnt_idx;
  logic              read_only;
  logic [CNT_W-1:0]  cnt_val [NUM_CNT];
  logic [NUM_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0]  cyc_val, tim_val, ret_val;
  logic [FLAG_W-1:0] flags_q;
  logic [RM_W-1:0]   rm_q;
  logic [DATA_W-1:0] old_val, new_val;
  logic              modifies, commit;
  logic              flags_we, rm_we;
  logic [FLAG_W-1:0] flags_wv;
  logic [RM_W-1:0]   rm_wv;
  logic [DATA_W-1:0] cnt_word;

  csr_decode #(.ADDR_W(ADDR_W), .HAS_HI(HAS_HI)) u_dec (
    .addr      (csr_addr),
    .sel       (sel),
    .cnt_idx   (cnt_idx),
    .read_only (read_only)
  );

  assign cnt_inc = {retire_pulse, time_tick, 1'b1};

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    csr_counter #(.WIDTH(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .inc   (cnt_inc[i]),
      .count (cnt_val[i])
    );
  end

  assign cyc_val = cnt_val[0];
  assign tim_val = cnt_val[1];
  assign ret_val = cnt_val[2];

  csr_fp_state #(.FLAG_W(FLAG_W), .RM_W(RM_W)) u_fp (
    .clk         (clk),
    .rst         (rst),
    .sw_flags_we (flags_we),
    .sw_flags    (flags_wv),
    .sw_rm_we    (rm_we),
    .sw_rm       (rm_wv),
    .hw_valid    (fpu_flag_valid),
    .hw_flags    (fpu_flags),
    .flags       (flags_q),
    .rmode       (rm_q)
  );

  always_comb begin
    cnt_word = '0;
    if (cnt_idx < 2'(NUM_CNT)) begin
      if (sel == SEL_CNT_HI) cnt_word = cnt_val[cnt_idx][CNT_W-1 -: DATA_W];
      else                   cnt_word = cnt_val[cnt_idx][DATA_W-1:0];
    end
  end

  always_comb begin
    case (sel)
      SEL_FLAGS:  old_val = DATA_W'(flags_q);
      SEL_RMODE:  old_val = DATA_W'(rm_q);
      SEL_FSTAT:  old_val = DATA_W'({rm_q, flags_q});
      SEL_CNT_LO,
      SEL_CNT_HI: old_val = cnt_word;
      default:    old_val = '0;
    endcase
  end

  always_comb begin
    case (csr_op)
      OP_WRITE: new_val = csr_wdata;
      OP_SET:   new_val = old_val | csr_wdata;
      OP_CLEAR: new_val = old_val & ~csr_wdata;
      default:  new_val = old_val;
    endcase
  end

  always_comb begin
    modifies    = (csr_op == OP_WRITE) ||
                  ((csr_op == OP_SET || csr_op == OP_CLEAR) && csr_wdata != '0);
    csr_illegal = csr_valid && (sel == SEL_NONE || (read_only && modifies));
    commit      = csr_valid && !csr_illegal && modifies;
    flags_we    = commit && (sel == SEL_FLAGS || sel == SEL_FSTAT);
    rm_we       = commit && (sel == SEL_RMODE || sel == SEL_FSTAT);
    flags_wv    = new_val[FLAG_W-1:0];
    rm_wv       = (sel == SEL_FSTAT) ? new_val[STAT_W-1:FLAG_W] : new_val[RM_W-1:0];
  end

  assign csr_rdata = old_val;

endmodule

// File: rtl/csr_unit_chk.sv
module csr_unit_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 64,
  parameter int FLAG_W = 5,
  parameter int RM_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              csr_valid,
  input logic [ADDR_W-1:0] csr_addr,
  input logic [DATA_W-1:0] csr_rdata,
  input logic              csr_illegal,
  input logic              time_tick,
  input logic              fpu_flag_valid,
  input logic [FLAG_W-1:0] fpu_flags,
  input logic [CNT_W-1:0]  cyc_val,
  input logic [CNT_W-1:0]  tim_val,
  input logic [FLAG_W-1:0] flags_q,
  input logic [RM_W-1:0]   rm_q
);

  assert_cycle_step_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cyc_val == $past(cyc_val) + 1'b1);

  assert_time_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !time_tick |=> $stable(tim_val));

  assert_time_step_R8: assert property (@(posedge clk) disable iff (rst)
    time_tick |=> tim_val == $past(tim_val) + 1'b1);

  assert_flags_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    fpu_flag_valid |=> (flags_q & $past(fpu_flags)) == $past(fpu_flags));

  assert_illegal_no_change_R9: assert property (@(posedge clk) disable iff (rst)
    (csr_valid && csr_illegal) |=> $stable(rm_q));

  assert_illegal_flags_keep_R10: assert property (@(posedge clk) disable iff (rst)
    (csr_valid && csr_illegal && !fpu_flag_valid) |=> $stable(flags_q));

  assert_idle_legal_R12: assert property (@(posedge clk) disable iff (rst)
    !csr_valid |-> !csr_illegal);

  assert_stat_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (csr_addr == 12'h003) |-> csr_rdata[DATA_W-1:FLAG_W+RM_W] == '0);

endmodule

bind csr_unit csr_unit_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .FLAG_W(FLAG_W), .RM_W(RM_W)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .csr_valid      (csr_valid),
  .csr_addr       (csr_addr),
  .csr_rdata      (csr_rdata),
  .csr_illegal    (csr_illegal),
  .time_tick      (time_tick),
  .fpu_flag_valid (fpu_flag_valid),
  .fpu_flags      (fpu_flags),
  .cyc_val        (cyc_val),
  .tim_val        (tim_val),
  .flags_q        (flags_q),
  .rm_q           (rm_q)
);

// File: tb/csr_unit_bench.sv
module csr_unit_bench;

  localparam int CLK_P  = 10;
  localparam int NVEC   = 15;
  localparam int VEC_W  = 80;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_valid = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [1:0]  csr_op = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        csr_illegal;
  logic        retire_pulse = 1'b0;
  logic        time_tick = 1'b0;
  logic        fpu_flag_valid = 1'b0;
  logic [4:0]  fpu_flags = '0;

  int total = 0;
  int bad   = 0;

  always #(CLK_P/2) clk = ~clk;

  csr_unit u_csr_unit (
    .clk(clk), .rst(rst), .csr_valid(csr_valid), .csr_addr(csr_addr),
    .csr_op(csr_op), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .csr_illegal(csr_illegal), .retire_pulse(retire_pulse),
    .time_tick(time_tick), .fpu_flag_valid(fpu_flag_valid), .fpu_flags(fpu_flags)
  );

  // {op, addr, wdata, exp_illegal, check_readback, exp_readback}
  localparam logic [VEC_W-1:0] VEC [NVEC] = '{
    {2'd1, 12'h001, 32'h0000_0015, 1'b0, 1'b1, 32'h0000_0015}, // R1 write
    {2'd1, 12'h002, 32'h0000_00FF, 1'b0, 1'b1, 32'h0000_0007}, // R2 write
    {2'd0, 12'h003, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_00F5}, // R3 alias
    {2'd1, 12'h003, 32'hFFFF_FF4A, 1'b0, 1'b1, 32'h0000_004A}, // R3 write
    {2'd0, 12'h001, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_000A}, // R3 -> flags
    {2'd2, 12'h001, 32'h0000_0011, 1'b0, 1'b1, 32'h0000_001B}, // R1 set
    {2'd3, 12'h002, 32'h0000_0002, 1'b0, 1'b1, 32'h0000_0000}, // R2 clear
    {2'd3, 12'h003, 32'h0000_0003, 1'b0, 1'b1, 32'h0000_0018}, // R3 clear
    {2'd1, 12'hC00, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_0000}, // R9 write
    {2'd2, 12'hC82, 32'h0000_0001, 1'b1, 1'b0, 32'h0000_0000}, // R9 set
    {2'd2, 12'hC01, 32'h0000_0000, 1'b0, 1'b0, 32'h0000_0000}, // R11 set 0
    {2'd3, 12'hC80, 32'h0000_0000, 1'b0, 1'b0, 32'h0000_0000}, // R11 clear 0
    {2'd0, 12'h7FF, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_0000}, // R10 read
    {2'd1, 12'h004, 32'h0000_0005, 1'b1, 1'b0, 32'h0000_0000}, // R10 write
    {2'd0, 12'h003, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_0018}  // R9 R10 kept
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] op, input logic [11:0] addr,
                        input logic [31:0] wd);
    @(negedge clk);
    csr_valid = 1'b1;
    csr_op    = op;
    csr_addr  = addr;
    csr_wdata = wd;
    #1;
  endtask

  task automatic read_at(input logic [11:0] addr, output logic [31:0] val);
    access(2'd0, addr, 32'h0);
    val = csr_rdata;
  endtask

  task automatic idle();
    @(negedge clk);
    csr_valid = 1'b0;
    csr_op    = 2'd0;
    #1;
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, a, b;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // reset state, R8
    read_at(12'h003, v); check("R8 reset status", v, 32'h0);
    read_at(12'hC01, v); check("R8 reset time", v, 32'h0);
    read_at(12'hC02, v); check("R8 reset retired", v, 32'h0);
    read_at(12'hC80, v); check("R7 cycle high", v, 32'h0);
    idle();
    check("R12 idle illegal", {31'b0, csr_illegal}, 32'h0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [VEC_W-1:0] e;
      e = VEC[i];
      access(e[79:78], e[77:66], e[65:34]);
      check("R9/R10/R11 illegal", {31'b0, csr_illegal}, {31'b0, e[33]});
      if (e[32]) begin
        read_at(e[77:66], v);
        check("R1/R2/R3 readback", v, e[31:0]);
      end
    end

    // R12: combinational read, update at next edge
    access(2'd1, 12'h002, 32'h5);
    check("R12 pre-edge value", csr_rdata, 32'h0);
    read_at(12'h002, v);
    check("R12 post-edge value", v, 32'h5);

    // R4 sticky accumulation (flags now 0x18)
    idle();
    fpu_flag_valid = 1'b1; fpu_flags = 5'h04;
    @(negedge clk); fpu_flags = 5'h01;
    @(negedge clk); fpu_flag_valid = 1'b0; fpu_flags = 5'h0;
    read_at(12'h001, v); check("R4 sticky", v, 32'h1D);

    // R5 collision of write and report
    access(2'd1, 12'h001, 32'h02);
    fpu_flag_valid = 1'b1; fpu_flags = 5'h10;
    @(negedge clk); fpu_flag_valid = 1'b0; fpu_flags = 5'h0;
    csr_op = 2'd0; #1;
    check("R5 write plus report", csr_rdata, 32'h12);
    access(2'd3, 12'h003, 32'h0000_001F);
    fpu_flag_valid = 1'b1; fpu_flags = 5'h08;
    @(negedge clk); fpu_flag_valid = 1'b0; fpu_flags = 5'h0;
    csr_op = 2'd0; #1;
    check("R5 clear plus report", csr_rdata, 32'hA8);

    // R6/R8 cycle counter
    read_at(12'hC00, a);
    repeat (4) idle();
    read_at(12'hC00, b);
    check("R6 R8 cycle step", b - a, 32'd5);

    // R8 time and retire
    idle();
    repeat (3) begin
      @(negedge clk); time_tick = 1'b1;
      @(negedge clk); time_tick = 1'b0;
    end
    repeat (4) begin
      @(negedge clk); retire_pulse = 1'b1;
    end
    @(negedge clk); retire_pulse = 1'b0;
    read_at(12'hC01, v); check("R6 R8 time count", v, 32'd3);
    read_at(12'hC02, v); check("R6 R8 retired count", v, 32'd4);
    read_at(12'hC81, v); check("R7 time high", v, 32'd0);
    read_at(12'hC82, v); check("R7 retired high", v, 32'd0);
    read_at(12'hC03, v);
    check("R10 hole after counters", {31'b0, csr_illegal}, 32'h1);

    // R9: refused write leaves counter unchanged
    access(2'd1, 12'hC02, 32'hFFFF_FFFF);
    check("R9 refused", {31'b0, csr_illegal}, 32'h1);
    read_at(12'hC02, v); check("R9 counter kept", v, 32'd4);

    // R8 reset again clears everything
    idle();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    read_at(12'hC01, v); check("R8 reset time again", v, 32'h0);
    read_at(12'h003, v); check("R8 reset status again", v, 32'h0);
    idle();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule